// File: doc/BRIEF.md
# Paged I2C EEPROM Target

This block is an I2C target that behaves like a small serial EEPROM holding 2 KB. The storage is split into eight blocks of 256 bytes. The upper three address bits do not come from strap pins. The controller sends them inside the control byte, next to a fixed device-type nibble and the direction bit. After the control byte comes a word address. That address selects a byte inside the chosen block.

The supported transfers are these:
- Single-byte writes.
- Page writes of up to 16 bytes. The address wraps inside the 16-byte page.
- Random reads, which use a dummy write followed by a repeated start.
- Current-address reads.
- Sequential reads that run through the whole 11-bit space, block after block.

A write-protect input makes the array read-only. The target keeps acknowledging while protect is high. The bus is open-drain. The block samples SCL and SDA with its system clock and pulls SDA low through an output-enable signal. It never drives SCL.

Top module: `i2c_paged_eeprom`

## Requirements
- R1: A control byte whose upper nibble is 1010 (binary) is acknowledged. Any other nibble gets no acknowledge. The block then drives nothing, for the rest of that transfer, until the next start condition, and the address pointer is unchanged.
- R2: In a write transfer, bits 3..1 of the control byte become address bits 10:8. The next byte becomes address bits 7:0. Each data byte that follows is stored at the pointer and acknowledged.
- R3: During a write, only the pointer's low 4 bits advance after each data byte, so the 17th byte of one transfer overwrites the first byte written in that 16-byte page.
- R4: A dummy write of the address, then a repeated start, then a control byte with bit 0 = 1, returns the byte at that address. For reads, bits 3..1 of the control byte are ignored.
- R5: Each byte sent during a read advances the full 11-bit pointer by one. The pointer crosses block boundaries, and 0x7FF is followed by 0x000.
- R6: When the controller answers a read byte with a not-acknowledge (SDA high), the block releases SDA. It drives nothing more until the next start condition.
- R7: While wp_i is high, data bytes are still acknowledged and the pointer still advances, but the array is not written. wp_i is sampled when the eighth bit of each data byte is taken, so raising it in the middle of a page protects only the bytes that follow.
- R8: A read that has no address phase starts from the pointer left by the previous transfer. That is one past the last byte read, or the in-page successor of the last byte written.
- R9: After reset, SDA is released (sda_oe = 0), and sda_o is always 0.
- R10: A stop condition releases SDA and ends the transfer. The pointer is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Level seen on the SCL line |
| sda_i | input | 1 | Level seen on the SDA line |
| wp_i | input | 1 | Write protect; high makes the array read-only |
| sda_o | output | 1 | Value driven onto SDA when enabled (always 0) |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
Two things can happen in the same cycle: the write-protect decision and the commit of a data byte. Both are taken in the cycle where the eighth SCL rising edge of the byte is seen. The bench raises wp_i halfway through a 16-byte page write, while SCL is low between two bytes. It then reads the page back. The test passes only if every byte before the change holds its new value and every byte after it keeps its old value, and every byte, including the protected ones, was acknowledged.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [3:0] EEP_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } eep_state_t;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDR,
    K_DATA
  } eep_kind_t;

endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] scl_q, scl_d;
  logic [CHAIN-1:0] sda_q, sda_d;
  logic scl_prev, sda_prev;

  always_comb begin
    scl_d = {scl_q[CHAIN-2:0], scl_i};
    sda_d = {sda_q[CHAIN-2:0], sda_i};
  end

  // idle bus reads high, so reset to ones to avoid a false start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_lvl   = scl_q[CHAIN-2];
  assign sda_lvl   = sda_q[CHAIN-2];
  assign scl_prev  = scl_q[CHAIN-1];
  assign sda_prev  = sda_q[CHAIN-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_data = mem[addr];

endmodule

// File: rtl/eep_engine.sv
module eep_engine
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BITS  = 4,
  parameter int BLOCK_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              wp_i,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              rd_ld,
  output logic              sda_oe
);

  localparam int         WORD_BITS = ADDR_W - BLOCK_BITS;
  localparam logic [3:0] LAST_BIT  = 4'd7;
  localparam logic [3:0] BYTE_FULL = 4'd8;

  eep_state_t        st_q, st_d;
  eep_kind_t         kind_q, kind_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              oe_q, oe_d;
  logic [7:0]        byte_in;
  logic              do_load;

  assign byte_in = {sh_q[6:0], sda_lvl};

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    do_load = 1'b0;
    if (start_det) begin
      st_d   = ST_RX;
      kind_d = K_CTRL;
      cnt_d  = '0;
      oe_d   = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
        end
        ST_RX: begin
          if (scl_rise && (cnt_q != BYTE_FULL)) begin
            sh_d  = byte_in;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              unique case (kind_q)
                K_CTRL: begin
                  if (byte_in[7:4] == EEP_TYPE) begin
                    rw_d = byte_in[0];
                    if (!byte_in[0]) begin
                      ptr_d[ADDR_W-1 -: BLOCK_BITS] = byte_in[BLOCK_BITS:1];
                    end
                  end else begin
                    st_d = ST_IDLE;
                  end
                end
                K_ADDR: begin
                  ptr_d[WORD_BITS-1:0] = byte_in[WORD_BITS-1:0];
                end
                K_DATA: begin
                  wr_en = !wp_i;
                  ptr_d[PAGE_BITS-1:0] = ptr_q[PAGE_BITS-1:0] + 1'b1;
                end
                default: st_d = ST_IDLE;
              endcase
            end
          end else if (scl_fall && (cnt_q == BYTE_FULL)) begin
            st_d = ST_ACK_OUT;
            oe_d = 1'b1;
          end
        end
        ST_ACK_OUT: begin
          if (scl_fall) begin
            cnt_d = '0;
            if ((kind_q == K_CTRL) && rw_q) begin
              do_load = 1'b1;
            end else begin
              st_d   = ST_RX;
              oe_d   = 1'b0;
              kind_d = (kind_q == K_CTRL) ? K_ADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              st_d = ST_ACK_IN;
              oe_d = 1'b0;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
              oe_d  = ~sh_q[6];
            end
          end
        end
        ST_ACK_IN: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              do_load = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (do_load) begin
      sh_d  = rd_data;
      ptr_d = ptr_q + 1'b1;
      st_d  = ST_TX;
      cnt_d = '0;
      oe_d  = ~rd_data[7];
    end
  end

  assign rd_ld = do_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= K_CTRL;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      oe_q   <= oe_d;
    end
  end

  assign wr_data = byte_in;
  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;

endmodule

// File: rtl/i2c_paged_eeprom.sv
module i2c_paged_eeprom #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BITS   = 4,
  parameter int BLOCK_BITS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_o,
  output logic sda_oe
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic              start_det, stop_det;
  logic              wr_en, rd_ld;
  logic [7:0]        wr_data, rd_data;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  eep_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eep_engine #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .BLOCK_BITS (BLOCK_BITS)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .wp_i      (wp_i),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .rd_ld     (rd_ld),
    .sda_oe    (sda_oe)
  );

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .addr    (ptr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  assign sda_o = 1'b0;

endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_BITS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic              wp_i,
  input logic              rd_ld,
  input logic [ADDR_W-1:0] ptr
);

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R10

  AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !wr_en); // R7

  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS]))); // R3

  AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ld |=> (ptr == ($past(ptr) + 1'b1))); // R5

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_lvl || $past(start_det || stop_det))); // R6

endmodule

bind i2c_paged_eeprom eep_checker #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_lvl   (scl_lvl),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .wp_i      (wp_i),
  .rd_ld     (rd_ld),
  .ptr       (ptr)
);

// File: tb/i2c_paged_eeprom_tb.sv
`timescale 1ns/1ps
module i2c_paged_eeprom_tb;

  localparam int Q = 4;

  logic clk, rst_n, scl, sda_m, wp;
  logic sda_o, sda_oe, sda_bus;
  int   n_cmp, n_bad;
  bit   done;

  logic [7:0]  mdl   [2048];
  bit          known [2048];
  logic [10:0] mptr;

  assign sda_bus = sda_m & ~(sda_oe & ~sda_o);

  i2c_paged_eeprom u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_bus),
    .wp_i   (wp),
    .sda_o  (sda_o),
    .sda_oe (sda_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tq(); scl = 1'b1; tq(); sda_m = 1'b0; tq(); scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tq(); scl = 1'b1; tq(); sda_m = 1'b1; tq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tq(); scl = 1'b1; tq(); tq(); scl = 1'b0; tq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tq(); scl = 1'b1; tq(); b = sda_bus; tq(); scl = 1'b0; tq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(nack);
  endtask

  task automatic set_addr(input logic [10:0] a, input string req);
    logic ack;
    bus_start();
    send_byte({4'b1010, a[10:8], 1'b0}, ack);
    check({req, " ctrl ack"}, {31'd0, ack}, 32'd0);
    send_byte(a[7:0], ack);
    check({req, " addr ack"}, {31'd0, ack}, 32'd0);
    mptr = a;
  endtask

  // wp_at: index of the data byte before which wp is raised, -1 for none
  task automatic write_txn(input logic [10:0] a, input int n, input int wp_at, input string req);
    logic ack;
    logic [7:0] v;
    set_addr(a, req);
    for (int i = 0; i < n; i++) begin
      if (i == wp_at) wp = 1'b1;
      v = 8'($urandom);
      send_byte(v, ack);
      check({req, " data ack"}, {31'd0, ack}, 32'd0);
      if (!wp) begin
        mdl[mptr]   = v;
        known[mptr] = 1'b1;
      end
      mptr[3:0] = mptr[3:0] + 4'd1;
    end
    bus_stop();
    check("R10 stop releases SDA", {31'd0, sda_oe}, 32'd0);
  endtask

  // read n bytes from the current pointer; repeated start if an address was just set
  task automatic read_seq(input int n, input string req);
    logic ack, probe;
    logic [7:0] v;
    bus_start();
    send_byte(8'b1010_111_1, ack);
    check({req, " read ctrl ack"}, {31'd0, ack}, 32'd0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, v);
      if (known[mptr]) check({req, " read data"}, {24'd0, v}, {24'd0, mdl[mptr]});
      mptr = mptr + 11'd1;
    end
    get_bit(probe);
    check("R6 released after NACK", {31'd0, probe}, 32'd1);
    bus_stop();
  endtask

  initial begin
    void'($urandom(32'd2718));
    n_cmp = 0; n_bad = 0; done = 1'b0;
    for (int i = 0; i < 2048; i++) known[i] = 1'b0;
    mptr = '0;
    scl = 1'b1; sda_m = 1'b1; wp = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 reset oe", {31'd0, sda_oe}, 32'd0);
    check("R9 sda_o low", {31'd0, sda_o}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 oe after reset", {31'd0, sda_oe}, 32'd0);

    // R2 R4 single byte write then random read
    write_txn(11'h123, 1, -1, "R2 byte write");
    set_addr(11'h123, "R4 dummy write");
    read_seq(1, "R4 random read");

    // R1 wrong type code, pointer must stay where the previous read left it
    begin
      logic ack;
      bus_start();
      send_byte(8'hB0, ack);
      check("R1 bad code no ack", {31'd0, ack}, 32'd1);
      send_byte(8'h55, ack);
      check("R1 ignored until start", {31'd0, ack}, 32'd1);
      bus_stop();
    end
    write_txn(11'h124, 2, -1, "R2 two bytes");
    set_addr(11'h123, "R8 setup");
    read_seq(1, "R8 setup read");
    read_seq(2, "R8 current address read");

    // R2 full page, R5 sequential read
    write_txn(11'h340, 16, -1, "R2 page write");
    set_addr(11'h340, "R5 page read");
    read_seq(16, "R5 page read");

    // R3 seventeen bytes from a mid-page start wrap inside the page
    write_txn(11'h205, 17, -1, "R3 page wrap");
    set_addr(11'h200, "R3 readback");
    read_seq(16, "R3 wrap readback");

    // R5 block boundary and top-of-array wrap
    write_txn(11'h0FE, 2, -1, "R5 block0 tail");
    write_txn(11'h100, 2, -1, "R5 block1 head");
    set_addr(11'h0FE, "R5 cross block");
    read_seq(4, "R5 cross block");
    write_txn(11'h7FF, 1, -1, "R5 top byte");
    write_txn(11'h000, 1, -1, "R5 bottom byte");
    set_addr(11'h7FF, "R5 array wrap");
    read_seq(2, "R5 array wrap");

    // R7 whole transfer under protect
    write_txn(11'h340, 4, 0, "R7 protected write");
    wp = 1'b0;
    set_addr(11'h340, "R7 readback");
    read_seq(4, "R7 unchanged");

    // R7 protect raised between byte 7 and byte 8 of a page
    write_txn(11'h3A0, 16, -1, "R7 preload");
    write_txn(11'h3A0, 16, 8, "R7 mid-page protect");
    wp = 1'b0;
    set_addr(11'h3A0, "R7 mid readback");
    read_seq(16, "R7 mid-page readback");

    // constrained random mix
    for (int it = 0; it < 10; it++) begin
      logic [10:0] a;
      int n;
      a = 11'($urandom);
      n = 1 + int'($urandom % 8);
      write_txn(a, n, -1, "R2 random write");
      set_addr(a, "R4 random addr");
      read_seq(n, "R5 random read");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule